// File: doc/BRIEF.md
# Fractional-N Clock Divider

The block turns a fast input clock into a slower output whose average period is a non-integer number of input cycles, a + b/c. Every output period is either a or a+1 input cycles long. A remainder accumulator modulo c gains b at each period boundary. When it reaches c it wraps, and the next period is stretched by one cycle. Over time the long and short periods mix so that the mean ratio comes out exactly.

The ratio comes from three configuration inputs, presented with a one-cycle load strobe. An accepted setting waits in a holding register and takes over only when the running period ends. Taking over clears the remainder. A setting outside the legal range is dropped and leaves everything as it was. Two outputs are produced: a square-ish clock that is high for the first half of each period, and a one-cycle tick that marks each period start.

Top module: `frac_clk_div`

## Requirements
- R1: After reset the ratio is 8 + 0/1. The first cycle after reset release is a period start: `clk_tick` and `clk_out` are both 1.
- R2: Every output period, measured from one `clk_tick` to the next, lasts either a or a+1 input cycles of the active setting.
- R3: While one setting stays active, any c consecutive periods that start from a cleared remainder contain exactly b long (a+1) periods.
- R4: When a period boundary is reached, the remainder is increased by b. If the sum is c or more, c is subtracted and the period that follows is a+1 cycles long; otherwise it is a cycles long. The remainder always stays below c.
- R5: With b = 0, every period lasts exactly a cycles.
- R6: Within a period of length L, `clk_out` is 1 for the first floor(L/2) cycles and 0 for the rest.
- R7: A setting loaded mid-period does not change the period that is running. It governs the periods from the next boundary on.
- R8: When a new setting takes over, the remainder is cleared to zero, so the first period under it is a short one (b < c).
- R9: A load is accepted only if c != 0, b < c, a >= 8, and a + b/c <= 1800 (that is, a < 1800, or a = 1800 with b = 0). Any other load is ignored: the period lengths go on exactly as if the load had not happened.
- R10: `clk_tick` is 1 only in the first cycle of each period, so it is never high on two consecutive cycles.
- R11: The limits are inclusive: a = 8 and a = 1800 with b = 0 are accepted. A = 1800 gives periods of exactly 1800 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | One-cycle strobe that presents a new ratio |
| cfg_int | input | 11 | Integer part a |
| cfg_num | input | 20 | Numerator b of the fraction |
| cfg_den | input | 20 | Denominator c of the fraction |
| clk_out | output | 1 | Divided clock, high for the first half of each period |
| clk_tick | output | 1 | One-cycle marker of each period start |

## Verification
A corrupted remainder shows up in the first period after the boundary that uses it. That period, or one a few periods later, comes out one cycle too long or too short against the exact long/short pattern predicted from b and c. A stray switch of the active setting or a missed clear shows up in the same way, in the length of the first period after the affected boundary. A wrong length register also moves the falling edge of `clk_out` within the same period. For these reasons the bench compares every single period length and high time, and does not just average the lengths over a long run.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;

  typedef struct packed {
    logic        wrap;
    logic [31:0] rem;
  } step_t;

  // add the numerator to the remainder, wrap modulo the denominator
  function automatic step_t acc_step(input logic [31:0] rem_in,
                                     input logic [31:0] num,
                                     input logic [31:0] den);
    step_t       r;
    logic [32:0] sum;
    sum = {1'b0, rem_in} + {1'b0, num};
    if (sum >= {1'b0, den}) begin
      r.wrap = 1'b1;
      r.rem  = 32'(sum - {1'b0, den});
    end else begin
      r.wrap = 1'b0;
      r.rem  = sum[31:0];
    end
    return r;
  endfunction

  // legal ratio window: amin <= a + b/c <= amax
  function automatic logic ratio_ok(input logic [31:0] a,
                                    input logic [31:0] b,
                                    input logic [31:0] c,
                                    input logic [31:0] amin,
                                    input logic [31:0] amax);
    logic ok;
    ok = (c != 32'd0) && (b < c) && (a >= amin);
    ok = ok && ((a < amax) || ((a == amax) && (b == 32'd0)));
    return ok;
  endfunction

endpackage

// File: rtl/frac_cfg_gate.sv
module frac_cfg_gate
  import frac_div_pkg::*;
#(
  parameter int INT_W   = 11,
  parameter int FRAC_W  = 20,
  parameter int A_MIN   = 8,
  parameter int A_MAX   = 1800,
  parameter int RST_INT = 8,
  parameter int RST_NUM = 0,
  parameter int RST_DEN = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [INT_W-1:0]  in_int,
  input  logic [FRAC_W-1:0] in_num,
  input  logic [FRAC_W-1:0] in_den,
  input  logic              boundary,
  output logic [INT_W-1:0]  act_int,
  output logic [FRAC_W-1:0] act_num,
  output logic [FRAC_W-1:0] act_den,
  output logic [INT_W-1:0]  nxt_int,
  output logic [FRAC_W-1:0] nxt_num,
  output logic [FRAC_W-1:0] nxt_den,
  output logic              nxt_fresh
);
  logic              load_ok;
  logic              pend_v;
  logic [INT_W-1:0]  pend_int;
  logic [FRAC_W-1:0] pend_num;
  logic [FRAC_W-1:0] pend_den;

  assign load_ok = load && ratio_ok(32'(in_int), 32'(in_num), 32'(in_den),
                                    32'(A_MIN), 32'(A_MAX));

  // holding register: a load at the boundary edge waits for the next one
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v   <= 1'b0;
      pend_int <= '0;
      pend_num <= '0;
      pend_den <= '0;
    end else if (load_ok) begin
      pend_v   <= 1'b1;
      pend_int <= in_int;
      pend_num <= in_num;
      pend_den <= in_den;
    end else if (boundary) begin
      pend_v   <= 1'b0;
    end
  end

  assign nxt_fresh = pend_v;
  assign nxt_int   = pend_v ? pend_int : act_int;
  assign nxt_num   = pend_v ? pend_num : act_num;
  assign nxt_den   = pend_v ? pend_den : act_den;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_int <= INT_W'(RST_INT);
      act_num <= FRAC_W'(RST_NUM);
      act_den <= FRAC_W'(RST_DEN);
    end else if (boundary) begin
      act_int <= nxt_int;
      act_num <= nxt_num;
      act_den <= nxt_den;
    end
  end
endmodule

// File: rtl/frac_phase_acc.sv
module frac_phase_acc
  import frac_div_pkg::*;
#(
  parameter int FRAC_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary,
  input  logic              nxt_fresh,
  input  logic [FRAC_W-1:0] nxt_num,
  input  logic [FRAC_W-1:0] nxt_den,
  output logic [FRAC_W-1:0] acc_q,
  output logic              nxt_long
);
  logic [FRAC_W-1:0] base;
  step_t             st;

  assign base     = nxt_fresh ? '0 : acc_q;
  assign st       = acc_step(32'(base), 32'(nxt_num), 32'(nxt_den));
  assign nxt_long = st.wrap;

  always_ff @(posedge clk) begin
    if (!rst_n)        acc_q <= '0;
    else if (boundary) acc_q <= FRAC_W'(st.rem);
  end
endmodule

// File: rtl/frac_period_ctr.sv
module frac_period_ctr #(
  parameter int INT_W   = 11,
  parameter int LEN_W   = 11,
  parameter int RST_INT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INT_W-1:0] nxt_int,
  input  logic             nxt_long,
  output logic             boundary,
  output logic             tick,
  output logic             clk_out,
  output logic [LEN_W-1:0] cur_len
);
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] half;

  assign boundary = (cnt == cur_len - LEN_W'(1));
  assign tick     = (cnt == '0);
  assign half     = cur_len >> 1;
  assign clk_out  = (cnt < half);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      cur_len <= LEN_W'(RST_INT);
    end else if (boundary) begin
      cnt     <= '0;
      cur_len <= LEN_W'(nxt_int) + LEN_W'(nxt_long);
    end else begin
      cnt     <= cnt + LEN_W'(1);
    end
  end
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div #(
  parameter int INT_W   = 11,
  parameter int FRAC_W  = 20,
  parameter int A_MIN   = 8,
  parameter int A_MAX   = 1800,
  parameter int RST_INT = 8,
  parameter int RST_NUM = 0,
  parameter int RST_DEN = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [INT_W-1:0]  cfg_int,
  input  logic [FRAC_W-1:0] cfg_num,
  input  logic [FRAC_W-1:0] cfg_den,
  output logic              clk_out,
  output logic              clk_tick
);
  localparam int LEN_W = $clog2(A_MAX + 2);

  // internal events, named for the checker
  logic              boundary;
  logic              nxt_fresh;
  logic              nxt_long;
  logic [INT_W-1:0]  act_int;
  logic [FRAC_W-1:0] act_num;
  logic [FRAC_W-1:0] act_den;
  logic [INT_W-1:0]  nxt_int;
  logic [FRAC_W-1:0] nxt_num;
  logic [FRAC_W-1:0] nxt_den;
  logic [FRAC_W-1:0] acc_q;
  logic [LEN_W-1:0]  cur_len;

  frac_cfg_gate #(
    .INT_W(INT_W), .FRAC_W(FRAC_W), .A_MIN(A_MIN), .A_MAX(A_MAX),
    .RST_INT(RST_INT), .RST_NUM(RST_NUM), .RST_DEN(RST_DEN)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(cfg_load),
    .in_int(cfg_int), .in_num(cfg_num), .in_den(cfg_den),
    .boundary(boundary),
    .act_int(act_int), .act_num(act_num), .act_den(act_den),
    .nxt_int(nxt_int), .nxt_num(nxt_num), .nxt_den(nxt_den),
    .nxt_fresh(nxt_fresh)
  );

  frac_phase_acc #(.FRAC_W(FRAC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .nxt_fresh(nxt_fresh),
    .nxt_num(nxt_num), .nxt_den(nxt_den),
    .acc_q(acc_q), .nxt_long(nxt_long)
  );

  frac_period_ctr #(.INT_W(INT_W), .LEN_W(LEN_W), .RST_INT(RST_INT)) u_ctr (
    .clk(clk), .rst_n(rst_n), .nxt_int(nxt_int), .nxt_long(nxt_long),
    .boundary(boundary), .tick(clk_tick), .clk_out(clk_out),
    .cur_len(cur_len)
  );
endmodule

// File: rtl/frac_clk_div_chk.sv
module frac_clk_div_chk #(
  parameter int INT_W  = 11,
  parameter int FRAC_W = 20,
  parameter int LEN_W  = 11,
  parameter int A_MIN  = 8,
  parameter int A_MAX  = 1800
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              boundary,
  input logic              clk_out,
  input logic              fresh,
  input logic [FRAC_W-1:0] acc_q,
  input logic [INT_W-1:0]  act_int,
  input logic [FRAC_W-1:0] act_num,
  input logic [FRAC_W-1:0] act_den,
  input logic [LEN_W-1:0]  cur_len
);
  assert_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (cur_len == LEN_W'(act_int)) || (cur_len == LEN_W'(act_int) + LEN_W'(1)));

  assert_rem_below_den_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < act_den);

  assert_exact_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && act_num == '0) |-> cur_len == LEN_W'(act_int));

  assert_high_at_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> clk_out);

  assert_low_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |-> !clk_out);

  assert_hold_midperiod_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> ($stable(act_int) && $stable(act_num) && $stable(act_den)));

  assert_clear_on_switch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && fresh) |=> acc_q == act_num);

  assert_active_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (act_den != '0) && (act_num < act_den) && (act_int >= INT_W'(A_MIN)) &&
    ((act_int < INT_W'(A_MAX)) || (act_num == '0 && act_int == INT_W'(A_MAX))));

  assert_single_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

bind frac_clk_div frac_clk_div_chk #(
  .INT_W(INT_W), .FRAC_W(FRAC_W), .LEN_W(LEN_W), .A_MIN(A_MIN), .A_MAX(A_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(clk_tick), .boundary(boundary),
  .clk_out(clk_out), .fresh(nxt_fresh), .acc_q(acc_q),
  .act_int(act_int), .act_num(act_num), .act_den(act_den), .cur_len(cur_len)
);

// File: tb/sim_frac_clk_div.sv
`timescale 1ns/1ps
module sim_frac_clk_div;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [10:0] cfg_int = '0;
  logic [19:0] cfg_num = '0;
  logic [19:0] cfg_den = '0;
  logic        clk_out;
  logic        clk_tick;

  always #5 clk = ~clk;

  frac_clk_div u0 (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_int(cfg_int),
    .cfg_num(cfg_num), .cfg_den(cfg_den), .clk_out(clk_out), .clk_tick(clk_tick)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  int    exp_q[$];
  int    qn = 0;
  string cur_req = "R1";
  bit    done = 0;

  // bench model of the ratio
  longint m_a = 8, m_b = 0, m_c = 1, m_acc = 0;
  int     win_a = 0, long_seen = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_len();
    longint s;
    s = m_acc + m_b;
    if (s >= m_c) begin m_acc = s - m_c; return int'(m_a + 1); end
    m_acc = s;
    return int'(m_a);
  endfunction

  // driver: push expected periods, then wait until only the running one remains
  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin exp_q.push_back(model_len()); qn++; end
    wait (qn == 1);
  endtask

  task automatic load(input int a, input int b, input int c, input bit legal, input string req);
    wait (qn == 1);
    cur_req  = req;
    cfg_int  = 11'(a);
    cfg_num  = 20'(b);
    cfg_den  = 20'(c);
    cfg_load = 1'b1;
    @(posedge clk);
    #1 cfg_load = 1'b0;
    if (legal) begin m_a = a; m_b = b; m_c = c; m_acc = 0; end
  endtask

  // monitor: measure each period and compare with the scoreboard
  int cyc = 0, hi = 0;
  bit started = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0; hi = 0; started = 0;
    end else if (clk_tick) begin
      if (started) begin
        if (qn == 0) chk(0, "R2 empty scoreboard", cyc, 0);
        else begin
          int e;
          e = exp_q.pop_front();
          qn--;
          chk(cyc == e, {cur_req, " R2 R4 R7 period length"}, cyc, e);
          chk(hi == e / 2, {cur_req, " R6 high time"}, hi, e / 2);
          if (cyc == win_a + 1) long_seen++;
        end
      end else begin
        chk(clk_out == 1'b1, "R1 clk_out at first cycle after reset", clk_out, 1);
      end
      cyc = 1; hi = int'(clk_out); started = 1;
    end else begin
      cyc++; hi += int'(clk_out);
      if (cyc > 1802) begin
        chk(0, "R10 missing tick", cyc, 1801);
        cyc = 0;
      end
    end
  end

  initial begin
    exp_q.push_back(model_len()); qn = 1;    // first period under reset setting
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk(clk_tick == 1'b1, "R1 tick at first cycle after reset", clk_tick, 1);
    cur_req = "R1 R5";
    run(3);                                   // reset ratio 8, exact

    load(10, 3, 7, 1, "R3 R7");
    win_a = 10; long_seen = 0;
    run(15);                                  // 14 new periods completed
    chk(long_seen == 6, "R3 long periods in two windows of 7", long_seen, 6);

    load(25, 0, 5, 1, "R5"); run(4);
    load(7, 0, 1, 0, "R9 a below minimum"); run(3);
    load(1801, 0, 1, 0, "R9 a above maximum"); run(2);
    load(1800, 1, 2, 0, "R9 ratio just above maximum"); run(2);
    load(12, 5, 5, 0, "R9 b equal to c"); run(2);
    load(12, 0, 0, 0, "R9 zero denominator"); run(2);
    load(1800, 0, 1, 1, "R11 top limit"); run(2);
    load(8, 1, 2, 1, "R4 R11 alternating"); run(7);
    load(8, 1, 2, 1, "R8 reload clears remainder"); run(3);
    load(9, 1000000, 1048575, 1, "R4 wide denominator"); run(8);
    load(11, 2, 3, 1, "R4 R10"); run(6);

    wait (qn == 1);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      chk(0, "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule